// File: doc/BRIEF.md
# One-Wire Identity Responder

This block is a single-drop slave on an open-drain one-wire bus. It watches the raw bus level and drives a pull-low enable. The bus level goes through a two-flop synchroniser. A parameterised divider makes a 1 µs tick from the system clock, and every delay in the block is a count of those ticks.

A watchdog starts on the first falling edge and restarts on every later falling edge. If no new edge arrives within 720 µs, the block treats the bus as being in reset. It waits for the bus to go high, waits 40 µs more, and then pulls the bus low for 150 µs as a presence pulse.

Between resets the block collects a command byte from the master's write slots. When the byte is 0x33, the block answers the next 64 master read slots with a fixed 64-bit identity. For a 0 bit it holds the bus low for about 30 µs from the master's falling edge. For a 1 bit it leaves the bus alone. Any other command byte is dropped, and the receiver starts a new byte with the next slot.

Top module: `owb_rom_slave`

## Requirements
- R1: After reset, drive_o is 0. The watchdog stays unarmed until the first falling edge, so an idle high bus never gets a pull-low, however long it stays idle.
- R2: The watchdog restarts on every falling edge seen while receiving or sending, and it expires 720 µs after the last one. If the bus is high at expiry, drive_o rises about 40 µs later (about 760 µs after that edge) and stays high for about 150 µs.
- R3: If the bus is still low when the watchdog expires, drive_o stays 0 until the bus goes high. Presence then starts about 40 µs after the release.
- R4: Each receive slot is sampled about 15 µs after its falling edge: a high level is 1 and a low level is 0. Bits arrive LSB first. A marker bit at the top of the shift register ends the byte after exactly 8 slots. A 1 slot held low for 20 µs is therefore read as 0.
- R5: After the byte 0x33, the next 64 slots carry ROM_ID, whose default bytes are 01 35 B1 87 09 00 00 68. Byte 0 is sent first and each byte is sent LSB first. A 0 bit pulls the bus low from the master's edge for about 30 µs, released well before 40 µs. A 1 bit pulls nothing.
- R6: Any other completed byte causes no pull-low in later slots. The next slot becomes bit 0 of a fresh byte.
- R7: After the 64th identity bit the block is back in receive mode, and further read slots see no pull-low.
- R8: Falling edges caused by the block's own driving are ignored. A presence pulse therefore never arms the watchdog, and a quiet bus after presence produces no further pull-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_i | input | 1 | Raw one-wire bus level, asynchronous |
| drive_o | output | 1 | Pull-low enable for the open-drain bus |

## Verification
Most wrong internal states reach the pins within one byte time.
- A receive marker that loses its place makes 0x33 go unseen. The following read slots then return 0xFF instead of 0x01.
- A wrong bit index or a bad serialiser step puts a wrong value into the first identity byte that is read back.
- A watchdog that restarts on the wrong edges, or that counts the wrong length, moves the presence start by whole microseconds on the first reset.
- A watchdog armed by the block's own pulse produces a spurious presence about 760 µs into the quiet period that follows a reset.

// File: rtl/owb_pkg.sv
`timescale 1ns/1ps
package owb_pkg;
  typedef enum logic [2:0] {
    ST_RX       = 3'd0,
    ST_TX       = 3'd1,
    ST_RST_HOLD = 3'd2,
    ST_PRES_GAP = 3'd3,
    ST_PRES     = 3'd4
  } owb_state_e;
endpackage

// File: rtl/owb_tick_gen.sv
`timescale 1ns/1ps
module owb_tick_gen #(
  parameter int unsigned DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/owb_bus_sync.sv
`timescale 1ns/1ps
module owb_bus_sync #(
  parameter int unsigned STAGES    = 2,
  parameter int unsigned MASK_HOLD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  input  logic drive_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0]    sync_q;
  logic                 prev_q;
  logic [MASK_HOLD-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      hold_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], bus_i};
      prev_q <= sync_q[STAGES-1];
      hold_q <= {hold_q[MASK_HOLD-2:0], drive_i};
    end
  end

  assign level_o = sync_q[STAGES-1];
  // own pull-low reaches the synchroniser a few cycles late; mask that window
  assign fall_o  = prev_q & ~level_o & ~drive_i & ~(|hold_q);
endmodule

// File: rtl/owb_us_timer.sv
`timescale 1ns/1ps
module owb_us_timer #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic         clear_i,
  input  logic [W-1:0] load_i,
  output logic         busy_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (clear_i) begin
      busy_o <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_i;
      busy_o <= 1'b1;
    end else if (busy_o && tick_i) begin
      if (cnt_q == W'(1)) busy_o <= 1'b0;
      else                cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o & tick_i & (cnt_q == W'(1));
endmodule

// File: rtl/owb_rx_byte.sv
`timescale 1ns/1ps
module owb_rx_byte #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sample_i,
  input  logic            bit_i,
  input  logic            clear_i,
  output logic [BITS-1:0] byte_o,
  output logic            done_o
);
  localparam logic [BITS-1:0] MARK = {1'b1, {(BITS-1){1'b0}}};

  logic [BITS-1:0] sh_q;

  assign byte_o = {bit_i, sh_q[BITS-1:1]};
  assign done_o = sample_i & sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sh_q <= MARK;
    else if (clear_i)       sh_q <= MARK;
    else if (sample_i)      sh_q <= sh_q[0] ? MARK : byte_o;
  end
endmodule

// File: rtl/owb_rom_slave.sv
`timescale 1ns/1ps
module owb_rom_slave
  import owb_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50,
  parameter int unsigned T_SAMPLE = 15,
  parameter int unsigned T_ZERO   = 30,
  parameter int unsigned T_RESET  = 720,
  parameter int unsigned T_GAP    = 40,
  parameter int unsigned T_PRES   = 150,
  parameter int unsigned ID_BYTES = 8,
  parameter logic [ID_BYTES*8-1:0] ROM_ID = 64'h6800_0009_87B1_3501,
  parameter logic [7:0] CMD_READ = 8'h33
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  output logic drive_o
);
  localparam int unsigned ID_BITS = ID_BYTES * 8;
  localparam int unsigned IW      = $clog2(ID_BITS);
  localparam int unsigned T_A     = (T_RESET > T_PRES) ? T_RESET : T_PRES;
  localparam int unsigned T_MAX   = (T_A > T_GAP) ? T_A : T_GAP;
  localparam int unsigned TW      = $clog2(T_MAX + 1);

  logic          tick;
  logic          bus_s, fall;
  logic          slot_start, slot_clear, slot_busy, slot_done;
  logic [TW-1:0] slot_load;
  logic          wd_start, wd_armed, wd_done;
  logic          rx_sample, rx_clear, rx_done;
  logic [7:0]    rx_byte;
  logic          active;

  owb_state_e    state_q, state_d;
  logic          drive_q, drive_d;
  logic [IW-1:0] idx_q, idx_d;

  owb_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  owb_bus_sync #(.STAGES(2), .MASK_HOLD(3)) i_sync (
    .clk_i  (clk_i), .rst_ni(rst_ni), .bus_i(bus_i), .drive_i(drive_q),
    .level_o(bus_s), .fall_o(fall)
  );

  owb_us_timer #(.W(TW)) i_slot_tmr (
    .clk_i  (clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .start_i(slot_start), .clear_i(slot_clear), .load_i(slot_load),
    .busy_o (slot_busy), .done_o(slot_done)
  );

  owb_us_timer #(.W(TW)) i_wd_tmr (
    .clk_i  (clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .start_i(wd_start), .clear_i(1'b0), .load_i(TW'(T_RESET)),
    .busy_o (wd_armed), .done_o(wd_done)
  );

  owb_rx_byte #(.BITS(8)) i_rx (
    .clk_i   (clk_i), .rst_ni(rst_ni), .sample_i(rx_sample), .bit_i(bus_s),
    .clear_i (rx_clear), .byte_o(rx_byte), .done_o(rx_done)
  );

  assign active    = (state_q == ST_RX) || (state_q == ST_TX);
  assign rx_sample = (state_q == ST_RX) && slot_done;
  assign wd_start  = active && fall;

  always_comb begin
    state_d    = state_q;
    drive_d    = drive_q;
    idx_d      = idx_q;
    slot_start = 1'b0;
    slot_clear = 1'b0;
    slot_load  = TW'(T_SAMPLE);
    rx_clear   = 1'b0;

    unique case (state_q)
      ST_RX: begin
        if (fall) slot_start = 1'b1;
        if (rx_done && rx_byte == CMD_READ) begin
          state_d = ST_TX;
          idx_d   = '0;
        end
      end
      ST_TX: begin
        if (fall && !slot_busy) begin
          slot_start = 1'b1;
          slot_load  = TW'(T_ZERO);
          drive_d    = ~ROM_ID[idx_q];
        end
        if (slot_done) begin
          drive_d = 1'b0;
          if (idx_q == IW'(ID_BITS - 1)) begin
            state_d = ST_RX;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_RST_HOLD: begin
        if (bus_s) begin
          slot_start = 1'b1;
          slot_load  = TW'(T_GAP);
          state_d    = ST_PRES_GAP;
        end
      end
      ST_PRES_GAP: begin
        if (slot_done) begin
          slot_start = 1'b1;
          slot_load  = TW'(T_PRES);
          drive_d    = 1'b1;
          state_d    = ST_PRES;
        end
      end
      ST_PRES: begin
        if (slot_done) begin
          drive_d  = 1'b0;
          rx_clear = 1'b1;
          state_d  = ST_RX;
        end
      end
      default: state_d = ST_RX;
    endcase

    // quiet bus for the full window: enter reset handling
    if (active && wd_armed && wd_done && !fall) begin
      state_d    = ST_RST_HOLD;
      drive_d    = 1'b0;
      idx_d      = '0;
      slot_start = 1'b0;
      slot_clear = 1'b1;
      rx_clear   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RX;
      drive_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      drive_q <= drive_d;
      idx_q   <= idx_d;
    end
  end

  assign drive_o = drive_q;
endmodule

// File: rtl/owb_rom_slave_chk.sv
`timescale 1ns/1ps
module owb_rom_slave_chk
  import owb_pkg::*;
#(
  parameter int unsigned ID_BITS = 64,
  parameter int unsigned IW      = 6,
  parameter logic [ID_BITS-1:0] ROM_ID = '0,
  parameter logic [7:0] CMD_READ = 8'h33,
  parameter int unsigned RUN_LIM = 7600
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          drive_i,
  input logic          bus_s_i,
  input owb_state_e    state_i,
  input logic [IW-1:0] idx_i,
  input logic          rx_done_i,
  input logic [7:0]    rx_byte_i,
  input logic          wd_armed_i
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (drive_i) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  a_r2_pull_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_LIM);

  a_r3_gap_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_RST_HOLD && state_i == ST_PRES_GAP) |-> $past(bus_s_i));

  a_r4_cmd_enters_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RX && rx_done_i && rx_byte_i == CMD_READ) |=> (state_i == ST_TX && idx_i == '0));

  a_r6_other_byte_stays_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RX && rx_done_i && rx_byte_i != CMD_READ) |=> state_i == ST_RX);

  a_r5_pull_only_for_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(drive_i) && state_i == ST_TX) |-> !ROM_ID[idx_i]);

  a_r7_tx_ends_at_last_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_TX && state_i == ST_RX) |-> $past(idx_i) == IW'(ID_BITS - 1));

  a_r8_pres_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PRES) |-> !wd_armed_i);
endmodule

bind owb_rom_slave owb_rom_slave_chk #(
  .ID_BITS (ID_BITS),
  .IW      (IW),
  .ROM_ID  (ROM_ID),
  .CMD_READ(CMD_READ),
  .RUN_LIM ((T_PRES + 2) * TICK_DIV)
) i_owb_rom_slave_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .drive_i   (drive_o),
  .bus_s_i   (bus_s),
  .state_i   (state_q),
  .idx_i     (idx_q),
  .rx_done_i (rx_done),
  .rx_byte_i (rx_byte),
  .wd_armed_i(wd_armed)
);

// File: tb/test_owb_rom_slave.sv
`timescale 1ns/1ps
module test_owb_rom_slave;
  localparam int  TICK_DIV = 5;
  localparam real US       = 20.0 * TICK_DIV;
  localparam logic [63:0] EXP_ID = 64'h6800_0009_87B1_3501;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic drive;
  logic bus;
  int n_chk = 0;
  int n_fail = 0;
  realtime t_last_fall;

  assign bus = ~(m_low | drive);
  always #10 clk = ~clk;

  owb_rom_slave #(.TICK_DIV(TICK_DIV)) i_owb_rom_slave (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .drive_o(drive)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    #(n * US);
  endtask

  task automatic watch_quiet(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      #(US);
      if (drive) hits++;
    end
  endtask

  task automatic measure_pres(input realtime t0, input int limit,
                              output int start_us, output int width_us);
    start_us = -1;
    width_us = 0;
    for (int i = 0; i < limit && start_us < 0; i++) begin
      #(US);
      if (drive) start_us = int'(($realtime - t0) / US);
    end
    while (drive && width_us < 400) begin
      #(US);
      width_us++;
    end
  endtask

  task automatic do_reset(input int low_us, input int exp_start, input string req);
    int hits, s, w;
    realtime t0;
    wait_us(1000);
    t0 = $realtime;
    m_low = 1'b1;
    hits = 0;
    for (int i = 0; i < low_us; i++) begin
      #(US);
      if (drive) hits++;
    end
    m_low = 1'b0;
    check(hits == 0, req, "pull-low while master holds reset", hits, 0);
    measure_pres(t0, 1300, s, w);
    check(s >= exp_start - 3 && s <= exp_start + 6, req, "presence start us", s, exp_start);
    check(w >= 146 && w <= 153, req, "presence width us", w, 150);
    wait_us(10);
  endtask

  task automatic write_byte(input logic [7:0] b, input int low1);
    for (int i = 0; i < 8; i++) begin
      m_low = 1'b1;
      t_last_fall = $realtime;
      if (b[i]) begin
        wait_us(low1); m_low = 1'b0; wait_us(75 - low1);
      end else begin
        wait_us(60); m_low = 1'b0; wait_us(15);
      end
    end
  endtask

  task automatic read_byte(output logic [7:0] v, output int late);
    v = '0;
    late = 0;
    for (int i = 0; i < 8; i++) begin
      m_low = 1'b1;
      t_last_fall = $realtime;
      wait_us(2);
      m_low = 1'b0;
      wait_us(11);
      v[i] = bus;
      wait_us(27);
      if (drive) late++;
      wait_us(35);
    end
  endtask

  task automatic test_reset_state();
    int h;
    check(drive == 1'b0, "R1", "drive_o after reset", drive, 0);
    watch_quiet(800, h);
    check(h == 0, "R1", "pull-low samples on idle bus", h, 0);
  endtask

  task automatic test_late_release();
    do_reset(900, 940, "R3");
  endtask

  task automatic test_read_rom();
    logic [7:0] v;
    int late, s, w;
    do_reset(500, 760, "R2");
    write_byte(8'h33, 6);
    for (int k = 0; k < 8; k++) begin
      read_byte(v, late);
      check(v == EXP_ID[k*8 +: 8], "R5", $sformatf("id byte %0d", k), v, EXP_ID[k*8 +: 8]);
      check(late == 0, "R5", "zero pulse released by 40us", late, 0);
    end
    read_byte(v, late);
    check(v == 8'hFF, "R7", "slots after last id bit", v, 8'hFF);
    measure_pres(t_last_fall, 1100, s, w);
    check(s >= 757 && s <= 766, "R2", "presence after quiet from last edge", s, 760);
    check(w >= 146 && w <= 153, "R2", "presence width after quiet", w, 150);
  endtask

  task automatic test_bad_command();
    logic [7:0] v;
    int late;
    do_reset(500, 760, "R6");
    write_byte(8'hF0, 6);
    read_byte(v, late);
    check(v == 8'hFF, "R6", "read after unknown command", v, 8'hFF);
    write_byte(8'h33, 6);
    read_byte(v, late);
    check(v == 8'h01, "R6", "command accepted after resync", v, 8'h01);
  endtask

  task automatic test_sample_point();
    logic [7:0] v;
    int late;
    do_reset(500, 760, "R4");
    write_byte(8'h33, 20);
    read_byte(v, late);
    check(v == 8'hFF, "R4", "ones held past sample point read as zero", v, 8'hFF);
    write_byte(8'h33, 12);
    read_byte(v, late);
    check(v == 8'h01, "R4", "ones released before sample point", v, 8'h01);
  endtask

  task automatic test_own_edges();
    int h;
    do_reset(500, 760, "R8");
    watch_quiet(1000, h);
    check(h == 0, "R8", "pull-low samples after presence", h, 0);
  endtask

  initial begin
    #3;
    wait_us(1);
    rst_n = 1'b1;
    wait_us(1);
    test_reset_state();
    test_late_release();
    test_read_rom();
    test_bad_command();
    test_sample_point();
    test_own_edges();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(195000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule